// File: doc/BRIEF.md
# Radio Configuration Word Serializer

This block loads a 14-bit setup word into the configuration register of a radio transceiver over a three-wire serial link. The link has a select line, a shift clock and a data line. The host offers the word on a parallel bus along with a small channel index and a clock divider value, then raises `start_i`. The block turns the channel index into the 8-bit channel number and places it in bits 9..2 of the word. It then frames the whole word with select held high and shifts it out most significant bit first. Each data bit is stable across the rising edge of the shift clock. The radio adopts the new setting when select falls.

The shift clock rate is set by a divider value, which is captured when a transfer is accepted. A transfer is refused while the radio sits in standby or power-down, and also while a transfer is already running. In either case an error pulse is raised. `ready_o` tells the host when a request will be taken. `done_o` marks the moment the new word has been committed.

Top module: `radio_cfg_shifter`

## Requirements
- R1: A transfer sends exactly 14 data bits, bit 13 first and bit 0 last, with one bit per shift-clock period. Every bit outside the channel field comes from `word_i` as it was in the cycle of acceptance.
- R2: Data changes only in the cycle where the shift clock falls, or when select rises. The shift clock is low whenever select is low, and data is low while select is low.
- R3: Select rises in the cycle after a start is accepted. It stays high through 14 clock periods plus one final low half period, which is 29 half periods in total. Then it falls.
- R4: Bits 9..2 of the transmitted word carry `chan_idx_i` multiplied by `CHAN_STEP`. With the default step of 4, indices 0, 1 and 2 give channels 0, 4 and 8.
- R5: A start made while `standby_i` or `pwrdn_i` is high has no effect: select stays low.
- R6: A start that is refused, because the block is busy or in standby or power-down, raises `err_o` for one cycle, in the cycle after the request.
- R7: `done_o` is high for exactly one cycle, the first cycle in which select reads low again. `ready_o` equals the inverse of select, so a start is taken in the cycle that `done_o` is high.
- R8: Each high phase and each low phase of the shift clock lasts `div_i`+1 system cycles. The value of `div_i` used is the one present at acceptance, and later changes to `div_i`, `word_i` or `chan_idx_i` do not alter a running transfer.
- R9: During and right after reset, select, shift clock, data, `done_o` and `err_o` are low and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transfer request |
| word_i | input | 14 | Setup word (bits 9..2 are replaced) |
| chan_idx_i | input | CHAN_W | Channel index |
| div_i | input | DIV_W | Half period of the shift clock, minus one |
| standby_i | input | 1 | Radio is in standby |
| pwrdn_i | input | 1 | Radio is powered down |
| ready_o | output | 1 | A start will be accepted if the radio is awake |
| done_o | output | 1 | One-cycle pulse as select falls |
| err_o | output | 1 | One-cycle pulse after a refused start |
| cfg_sel_o | output | 1 | Active-high select |
| cfg_clk_o | output | 1 | Shift clock to the radio |
| cfg_data_o | output | 1 | Serial configuration data |

## Verification
The bench aims at the following edges of the protocol:
- **Back-to-back request.** A request held high across the `done_o` cycle must start the next transfer at once. A design that keeps busy one cycle too long would instead flag an error and lose a whole word.
- **Divider change mid-transfer.** `div_i` is changed during a running transfer. A design that does not capture the divider would stretch or shrink the half periods.
- **Requests while asleep or busy.** Requests arrive during standby, during power-down and while a transfer is running. A missing guard would raise select or restart the shift, corrupting the register.
- **Channel field and bit order.** The word is rebuilt from the shift clock's rising edges and compared against the expected channel field. This catches a reversed bit order or a misplaced field.

// File: rtl/radio_cfg_pkg.sv
package radio_cfg_pkg;
  localparam int unsigned CFG_BITS = 14;
  localparam int unsigned CH_LSB   = 2;
  localparam int unsigned CH_BITS  = 8;

  typedef logic [CFG_BITS-1:0] cfg_word_t;
  typedef logic [CH_BITS-1:0]  chan_code_t;

  // channel number = index * step, truncated to the field width
  function automatic chan_code_t chan_code(input int unsigned idx, input int unsigned step);
    int unsigned prod;
    prod = idx * step;
    return prod[CH_BITS-1:0];
  endfunction

  // overwrite the channel field of a host word
  function automatic cfg_word_t merge_chan(input cfg_word_t w, input chan_code_t ch);
    cfg_word_t r;
    r = w;
    r[CH_LSB +: CH_BITS] = ch;
    return r;
  endfunction
endpackage

// File: rtl/cfg_word_builder.sv
module cfg_word_builder
  import radio_cfg_pkg::*;
#(
  parameter int unsigned CHAN_W    = 2,
  parameter int unsigned CHAN_STEP = 4
) (
  input  cfg_word_t         word_i,
  input  logic [CHAN_W-1:0] chan_idx_i,
  output cfg_word_t         word_o
);
  chan_code_t ch_num;

  assign ch_num = chan_code(int'(chan_idx_i), CHAN_STEP);
  assign word_o = merge_chan(word_i, ch_num);
endmodule

// File: rtl/cfg_half_timer.sv
module cfg_half_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] lat_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      lat_q <= div_i;
      cnt_q <= '0;
    end else if (run_i) begin
      if (cnt_q == lat_q) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == lat_q);
endmodule

// File: rtl/cfg_shift_engine.sv
module cfg_shift_engine
  import radio_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept_i,
  input  cfg_word_t word_i,
  input  logic      tick_i,
  output logic      busy_o,
  output logic      sclk_o,
  output logic      sdat_o,
  output logic      done_o,
  output logic      rise_o,
  output logic      fall_o,
  output logic      fin_o
);
  localparam int unsigned BIT_W = $clog2(CFG_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CFG_BITS - 1);

  logic             busy_q, sclk_q, tail_q, done_q;
  cfg_word_t        sh_q;
  logic [BIT_W-1:0] bit_q;

  assign rise_o = tick_i && busy_q && !sclk_q && !tail_q;
  assign fall_o = tick_i && busy_q && sclk_q;
  assign fin_o  = tick_i && busy_q && !sclk_q && tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      tail_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
    end else begin
      done_q <= fin_o;
      if (accept_i) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        tail_q <= 1'b0;
        sh_q   <= word_i;
        bit_q  <= '0;
      end else if (rise_o) begin
        sclk_q <= 1'b1;
      end else if (fall_o) begin
        sclk_q <= 1'b0;
        if (bit_q == LAST_BIT) begin
          tail_q <= 1'b1;
        end else begin
          sh_q  <= {sh_q[CFG_BITS-2:0], 1'b0};
          bit_q <= bit_q + 1'b1;
        end
      end else if (fin_o) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign sclk_o = sclk_q;
  assign sdat_o = busy_q & sh_q[CFG_BITS-1];
  assign done_o = done_q;
endmodule

// File: rtl/radio_cfg_shifter.sv
module radio_cfg_shifter
  import radio_cfg_pkg::*;
#(
  parameter int unsigned CHAN_W    = 2,
  parameter int unsigned CHAN_STEP = 4,
  parameter int unsigned DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [13:0]       word_i,
  input  logic [CHAN_W-1:0] chan_idx_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              standby_i,
  input  logic              pwrdn_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cfg_sel_o,
  output logic              cfg_clk_o,
  output logic              cfg_data_o
);
  cfg_word_t built_word;
  logic      busy, accept, reject, half_tick;
  logic      rise_ev, fall_ev, fin_ev;
  logic      err_q;

  assign accept = start_i && !busy && !standby_i && !pwrdn_i;
  assign reject = start_i && !accept;

  cfg_word_builder #(.CHAN_W(CHAN_W), .CHAN_STEP(CHAN_STEP)) u_build (
    .word_i     (word_i),
    .chan_idx_i (chan_idx_i),
    .word_o     (built_word)
  );

  cfg_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .div_i  (div_i),
    .run_i  (busy),
    .tick_o (half_tick)
  );

  cfg_shift_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .word_i   (built_word),
    .tick_i   (half_tick),
    .busy_o   (busy),
    .sclk_o   (cfg_clk_o),
    .sdat_o   (cfg_data_o),
    .done_o   (done_o),
    .rise_o   (rise_ev),
    .fall_o   (fall_ev),
    .fin_o    (fin_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= reject;
  end

  assign err_o     = err_q;
  assign ready_o   = !busy;
  assign cfg_sel_o = busy;
endmodule

// File: rtl/radio_cfg_shifter_chk.sv
module radio_cfg_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic standby_i,
  input logic pwrdn_i,
  input logic busy,
  input logic accept,
  input logic rise_ev,
  input logic fall_ev,
  input logic fin_ev,
  input logic done_o,
  input logic err_o,
  input logic cfg_sel_o,
  input logic cfg_clk_o,
  input logic cfg_data_o
);
  logic [4:0] rises_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rises_q <= '0;
    else if (accept)  rises_q <= '0;
    else if (rise_ev) rises_q <= rises_q + 1'b1;
  end

  p_fourteen_rises_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ev |-> rises_q == 5'd14);

  p_data_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel_o && $past(cfg_sel_o) && !$stable(cfg_data_o)) |-> $fell(cfg_clk_o));

  p_clk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel_o |-> (!cfg_clk_o && !cfg_data_o));

  p_fall_is_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> $fell(cfg_clk_o));

  p_sel_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cfg_sel_o && !cfg_clk_o));

  p_sel_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ev |=> $fell(cfg_sel_o));

  p_asleep_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && (standby_i || pwrdn_i)) |=> !cfg_sel_o);

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (busy || standby_i || pwrdn_i)) |=> err_o);

  p_done_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_sel_o) |-> done_o);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind radio_cfg_shifter radio_cfg_shifter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .standby_i  (standby_i),
  .pwrdn_i    (pwrdn_i),
  .busy       (busy),
  .accept     (accept),
  .rise_ev    (rise_ev),
  .fall_ev    (fall_ev),
  .fin_ev     (fin_ev),
  .done_o     (done_o),
  .err_o      (err_o),
  .cfg_sel_o  (cfg_sel_o),
  .cfg_clk_o  (cfg_clk_o),
  .cfg_data_o (cfg_data_o)
);

// File: tb/radio_cfg_shifter_test.sv
module radio_cfg_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [13:0] word_i = '0;
  logic [1:0]  chan_idx_i = '0;
  logic [7:0]  div_i = '0;
  logic        standby_i = 1'b0;
  logic        pwrdn_i = 1'b0;
  logic        ready_o, done_o, err_o, cfg_sel_o, cfg_clk_o, cfg_data_o;

  int tests = 0;
  int fails = 0;

  // model state: entries are {done, sel, clk, data}
  logic [3:0]  exp_q[$];
  logic [3:0]  cur = 4'b0000;
  logic        exp_err = 1'b0;
  logic [13:0] exp_word = '0;
  logic [13:0] cap_word = '0;
  logic        prev_clk = 1'b0;
  int          exp_chan = 0;

  always #2 clk = ~clk;

  radio_cfg_shifter uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
    .chan_idx_i(chan_idx_i), .div_i(div_i), .standby_i(standby_i),
    .pwrdn_i(pwrdn_i), .ready_o(ready_o), .done_o(done_o), .err_o(err_o),
    .cfg_sel_o(cfg_sel_o), .cfg_clk_o(cfg_clk_o), .cfg_data_o(cfg_data_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // one system cycle: predict from inputs, advance, compare at negedge
  task automatic step();
    logic mbusy;
    int   h;
    mbusy   = cur[2];
    exp_err = start_i && (mbusy || standby_i || pwrdn_i);
    if (start_i && !mbusy && !standby_i && !pwrdn_i) begin
      exp_chan = int'(chan_idx_i) * 4;
      exp_word = (word_i & ~(14'hFF << 2)) | 14'((exp_chan & 255) << 2);
      h = int'(div_i) + 1;
      for (int b = 13; b >= 0; b--) begin
        for (int k = 0; k < h; k++) exp_q.push_back({2'b01, 1'b0, exp_word[b]});
        for (int k = 0; k < h; k++) exp_q.push_back({2'b01, 1'b1, exp_word[b]});
      end
      for (int k = 0; k < h; k++) exp_q.push_back({2'b01, 1'b0, exp_word[0]});
      exp_q.push_back(4'b1000);
    end
    @(posedge clk);
    @(negedge clk);
    cur = (exp_q.size() > 0) ? exp_q.pop_front() : 4'b0000;
    chk("R3 select", int'(cfg_sel_o), int'(cur[2]));
    chk("R2 shift clock", int'(cfg_clk_o), int'(cur[1]));
    chk("R1 data bit", int'(cfg_data_o), int'(cur[0]));
    chk("R7 done", int'(done_o), int'(cur[3]));
    chk("R7 ready", int'(ready_o), int'(!cur[2]));
    chk("R6 error", int'(err_o), int'(exp_err));
    if (cfg_sel_o && cfg_clk_o && !prev_clk) cap_word = {cap_word[12:0], cfg_data_o};
    prev_clk = cfg_clk_o;
    if (done_o) begin
      chk("R1 rebuilt word", int'(cap_word), int'(exp_word));
      chk("R4 channel field", int'(cap_word[9:2]), exp_chan);
    end
  endtask

  task automatic run_until_idle();
    while (exp_q.size() > 0) step();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R9 reset select", int'(cfg_sel_o), 0);
    chk("R9 reset clock", int'(cfg_clk_o), 0);
    chk("R9 reset data", int'(cfg_data_o), 0);
    chk("R9 reset done/err", int'({done_o, err_o}), 0);
    chk("R9 reset ready", int'(ready_o), 1);
    rst_n = 1'b1;
    step();

    // all-ones word, channel index 0, fastest divider
    word_i = 14'h3FFF; chan_idx_i = 2'd0; div_i = 8'd0;
    start_i = 1'b1; step(); start_i = 1'b0;
    run_until_idle(); step();

    // divider and inputs changed mid-transfer, plus a request while busy (R8, R6)
    word_i = 14'h1555; chan_idx_i = 2'd1; div_i = 8'd2;
    start_i = 1'b1; step(); start_i = 1'b0;
    repeat (10) step();
    div_i = 8'd7; word_i = 14'h0000; chan_idx_i = 2'd3;
    start_i = 1'b1; step(); start_i = 1'b0;
    run_until_idle(); step();

    // requests while asleep (R5)
    standby_i = 1'b1; start_i = 1'b1; step(); start_i = 1'b0; step();
    chk("R5 standby keeps select low", int'(cfg_sel_o), 0);
    standby_i = 1'b0; pwrdn_i = 1'b1; start_i = 1'b1; step(); start_i = 1'b0; step();
    chk("R5 power-down keeps select low", int'(cfg_sel_o), 0);
    pwrdn_i = 1'b0;

    // request held high: back-to-back transfers (R7)
    word_i = 14'h2A5C; chan_idx_i = 2'd2; div_i = 8'd1;
    start_i = 1'b1;
    for (int n = 0; n < 2 * (29 * 2 + 1) + 1; n++) step();
    start_i = 1'b0;
    run_until_idle();
    repeat (3) step();
    summary();
  end
endmodule